// File: doc/BRIEF.md
# Code-Programmed Bit-Slice ALU

This block is an N-bit combinational arithmetic and logic unit built from identical one-bit slices. Each slice has three generic function units. Each unit is a 4-to-1 selector whose four data inputs come from a 4-bit truth-table code and whose two select lines come from two signal bits.

The propagate unit and the kill unit both look at the operand bits. The result unit looks at the slice's propagate bit and the carry that enters the slice. A fixed carry cell in each slice forms the next carry from the propagate bit, the kill bit and the incoming carry. The carries ripple from bit 0 upward.

No operation is hard-wired. The caller selects a logic function, an add, an increment or a subtract by loading three 4-bit codes and a 2-bit carry-in selector. The block has no clock and no state. The result and the carry/borrow out settle from the present inputs alone.

Top module: `coded_slice_alu`

## Requirements
- R1: Propagate bit i equals p_code[2*opa[i] + opb[i]]. With r_code = 12, result[i] equals that propagate bit for every one of the 16 possible p_code values. Examples: p_code 8 gives AND, 14 gives OR, 6 gives XOR and 12 passes opa.
- R2: With r_code = 12, the result word does not depend on cin or cin_sel. Changing them leaves result unchanged.
- R3: The carry into bit 0 is chosen by cin_sel: 0 gives constant 0, 1 gives constant 1, 2 gives the cin pin, and 3 gives constant 0.
- R4: Each carry cell computes c[i+1] = P[i]&c[i] | ~P[i]&~K[i], where K[i] = k_code[2*opa[i] + opb[i]]. The output cout is c[WIDTH].
- R5: Result bit i equals r_code[2*P[i] + c[i]] for any code values.
- R6: Add uses codes (p, k, r) = (6, 1, 6). It gives {cout, result} = opa + opb + c0, where c0 is the R3 carry-in: 0 for plain add, the cin pin for add-with-carry.
- R7: Increment uses codes (12, 3, 6) with cin_sel = 1. It gives result = opa + 1 mod 2^WIDTH, and cout = 1 exactly when opa is all ones.
- R8: Subtract uses codes (9, 4, 9). It gives result = opa - opb - b0 mod 2^WIDTH, where b0 is the R3 carry-in used as a borrow. cout is 1 exactly when opa < opb + b0.
- R9: Reverse subtract uses codes (9, 2, 9). It gives result = opb - opa - b0 mod 2^WIDTH, and cout is 1 exactly when opb < opa + b0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand; high select line of the propagate and kill units |
| opb | input | WIDTH | Second operand; low select line of the propagate and kill units |
| cin | input | 1 | External carry-in or borrow-in, used when cin_sel = 2 |
| p_code | input | 4 | Truth-table code of the propagate units |
| k_code | input | 4 | Truth-table code of the kill units |
| r_code | input | 4 | Truth-table code of the result units |
| cin_sel | input | 2 | Carry-in source: 0 zero, 1 one, 2 cin pin, 3 zero |
| result | output | WIDTH | Result word |
| cout | output | 1 | Carry or borrow out of the top slice |

## Verification
The assertions assume that every input holds a known 0 or 1 level. They also assume the three codes arrive together with the operands, so no check fires on a half-updated code set. Each arithmetic check applies only when the codes match one of the named operation patterns exactly. Other code combinations leave these checks idle.

The stimulus changes all inputs in one step at a rising clock edge and samples at the falling edge. It drives the don't-care codes of logic operations to 0. It reaches arbitrary code combinations only in the scenario that compares against the per-slice equations.

// File: rtl/csalu_pkg.sv
package csalu_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    CSEL_ZERO = 2'd0,
    CSEL_ONE  = 2'd1,
    CSEL_EXT  = 2'd2,
    CSEL_RSVD = 2'd3
  } csel_e;

  // Truth-table codes, bit index = 2*high_select + low_select
  localparam logic [CODE_W-1:0] FC_NOR   = 4'd1;
  localparam logic [CODE_W-1:0] FC_NAB   = 4'd2;
  localparam logic [CODE_W-1:0] FC_NOTA  = 4'd3;
  localparam logic [CODE_W-1:0] FC_ANB   = 4'd4;
  localparam logic [CODE_W-1:0] FC_XOR   = 4'd6;
  localparam logic [CODE_W-1:0] FC_AND   = 4'd8;
  localparam logic [CODE_W-1:0] FC_XNOR  = 4'd9;
  localparam logic [CODE_W-1:0] FC_PASSA = 4'd12;
  localparam logic [CODE_W-1:0] FC_OR    = 4'd14;
endpackage

// File: rtl/gfu_mux.sv
module gfu_mux
  import csalu_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              sel_hi,
  input  logic              sel_lo,
  output logic              y
);
  always_comb begin
    unique case ({sel_hi, sel_lo})
      2'b00:   y = code[0];
      2'b01:   y = code[1];
      2'b10:   y = code[2];
      default: y = code[3];
    endcase
  end
endmodule

// File: rtl/carry_cell.sv
module carry_cell (
  input  logic prop,
  input  logic kill,
  input  logic c_in,
  output logic c_out
);
  // Carry passes through when propagating, otherwise generated unless killed
  assign c_out = prop ? c_in : ~kill;
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import csalu_pkg::*;
(
  input  logic              a_bit,
  input  logic              b_bit,
  input  logic              c_in,
  input  logic [CODE_W-1:0] p_code,
  input  logic [CODE_W-1:0] k_code,
  input  logic [CODE_W-1:0] r_code,
  output logic              r_bit,
  output logic              c_out
);
  logic prop;
  logic kill;

  gfu_mux u_prop (.code(p_code), .sel_hi(a_bit), .sel_lo(b_bit), .y(prop));
  gfu_mux u_kill (.code(k_code), .sel_hi(a_bit), .sel_lo(b_bit), .y(kill));
  gfu_mux u_res  (.code(r_code), .sel_hi(prop),  .sel_lo(c_in),  .y(r_bit));

  carry_cell u_cc (.prop(prop), .kill(kill), .c_in(c_in), .c_out(c_out));
endmodule

// File: rtl/coded_slice_alu.sv
module coded_slice_alu
  import csalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic              cin,
  input  logic [CODE_W-1:0] p_code,
  input  logic [CODE_W-1:0] k_code,
  input  logic [CODE_W-1:0] r_code,
  input  logic [1:0]        cin_sel,
  output logic [WIDTH-1:0]  result,
  output logic              cout
);
  localparam int CHAIN_W = WIDTH + 1;

  logic [CHAIN_W-1:0] chain;

  always_comb begin
    unique case (csel_e'(cin_sel))
      CSEL_ZERO: chain[0] = 1'b0;
      CSEL_ONE:  chain[0] = 1'b1;
      CSEL_EXT:  chain[0] = cin;
      default:   chain[0] = 1'b0;
    endcase
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_bit  (opa[i]),
      .b_bit  (opb[i]),
      .c_in   (chain[i]),
      .p_code (p_code),
      .k_code (k_code),
      .r_code (r_code),
      .r_bit  (result[i]),
      .c_out  (chain[i+1])
    );
  end

  assign cout = chain[WIDTH];
endmodule

// File: rtl/coded_slice_alu_chk.sv
module coded_slice_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             cin,
  input logic [3:0]       p_code,
  input logic [3:0]       k_code,
  input logic [3:0]       r_code,
  input logic [1:0]       cin_sel,
  input logic [WIDTH-1:0] result,
  input logic             cout
);
  logic           c0;
  logic [WIDTH:0] wa, wb, wc, got;

  always_comb begin
    c0  = (cin_sel == 2'd1) | ((cin_sel == 2'd2) & cin);
    wa  = {1'b0, opa};
    wb  = {1'b0, opb};
    wc  = {{WIDTH{1'b0}}, c0};
    got = {cout, result};
    if (p_code == 4'd6 && k_code == 4'd1 && r_code == 4'd6) begin
      // R6
      add_sum_chk: assert (got == wa + wb + wc);
    end
    if (p_code == 4'd12 && k_code == 4'd3 && r_code == 4'd6 && cin_sel == 2'd1) begin
      // R7
      incr_wrap_chk: assert (got == wa + 1'b1);
    end
    if (p_code == 4'd9 && k_code == 4'd4 && r_code == 4'd9) begin
      // R8
      sub_borrow_chk: assert (got == wa - wb - wc);
    end
    if (p_code == 4'd9 && k_code == 4'd2 && r_code == 4'd9) begin
      // R9
      rsub_borrow_chk: assert (got == wb - wa - wc);
    end
    if (p_code == 4'd8 && r_code == 4'd12) begin
      // R1
      and_logic_chk: assert (result == (opa & opb));
    end
  end
endmodule

bind coded_slice_alu coded_slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa(opa), .opb(opb), .cin(cin), .p_code(p_code), .k_code(k_code),
  .r_code(r_code), .cin_sel(cin_sel), .result(result), .cout(cout)
);

// File: tb/tb_coded_slice_alu.sv
module tb_coded_slice_alu;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] opa = '0, opb = '0;
  logic         cin = 1'b0;
  logic [3:0]   p_code = '0, k_code = '0, r_code = '0;
  logic [1:0]   cin_sel = '0;
  logic [W-1:0] result;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  coded_slice_alu #(.WIDTH(W)) dut (
    .opa(opa), .opb(opb), .cin(cin), .p_code(p_code), .k_code(k_code),
    .r_code(r_code), .cin_sel(cin_sel), .result(result), .cout(cout)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h p=%0d k=%0d r=%0d sel=%0d cin=%0b)",
               req, act, exp, opa, opb, p_code, k_code, r_code, cin_sel, cin);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] p, input logic [3:0] k, input logic [3:0] r,
                       input logic [1:0] sel, input logic ci);
    @(posedge clk);
    opa = a; opb = b; p_code = p; k_code = k; r_code = r; cin_sel = sel; cin = ci;
    @(negedge clk);
  endtask

  function automatic logic c0_of(input logic [1:0] sel, input logic ci);
    return (sel == 2'd1) || (sel == 2'd2 && ci);
  endfunction

  // Per-slice equations from R1, R3, R4, R5
  function automatic logic [W:0] slice_ref(input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [3:0] p, input logic [3:0] k, input logic [3:0] r,
      input logic [1:0] sel, input logic ci);
    logic c;
    logic [W-1:0] res;
    c = c0_of(sel, ci);
    for (int i = 0; i < W; i++) begin
      logic pb, kb;
      pb = p[{a[i], b[i]}];
      kb = k[{a[i], b[i]}];
      res[i] = r[{pb, c}];
      c = (pb & c) | (~pb & ~kb);
    end
    return {c, res};
  endfunction

  task automatic t_idle_state;
    @(negedge clk);
    // all-zero codes: kill 0 generates carries, result code 0 gives zero (R4, R5)
    check("R4", {cout, result}, {1'b1, {W{1'b0}}});
  endtask

  task automatic t_logic_codes;
    for (int c = 0; c < 16; c++) begin
      logic [W-1:0] a, b, e;
      a = W'($urandom); b = W'($urandom);
      for (int i = 0; i < W; i++) e[i] = c[{a[i], b[i]}];
      drive(a, b, 4'(c), 4'd0, 4'd12, 2'd0, 1'b0);
      check("R1", {1'b0, result}, {1'b0, e});
    end
    drive(8'hC3, 8'hA5, 4'd8, 4'd0, 4'd12, 2'd0, 1'b0);
    check("R1 and", {1'b0, result}, {1'b0, 8'h81});
    drive(8'hC3, 8'hA5, 4'd14, 4'd0, 4'd12, 2'd0, 1'b0);
    check("R1 or", {1'b0, result}, {1'b0, 8'hE7});
  endtask

  task automatic t_carry_ignored;
    for (int s = 0; s < 4; s++) begin
      drive(8'h5A, 8'h3C, 4'd6, 4'd0, 4'd12, 2'(s), 1'b1);
      check("R2", {1'b0, result}, {1'b0, 8'h66});
      drive(8'h5A, 8'h3C, 4'd6, 4'd0, 4'd12, 2'(s), 1'b0);
      check("R2", {1'b0, result}, {1'b0, 8'h66});
    end
  endtask

  task automatic t_cin_select;
    for (int s = 0; s < 4; s++)
      for (int ci = 0; ci < 2; ci++) begin
        drive('0, '0, 4'd6, 4'd1, 4'd6, 2'(s), 1'(ci));
        check("R3", {cout, result}, {{W{1'b0}}, c0_of(2'(s), 1'(ci))});
      end
  endtask

  task automatic t_add;
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] a, b;
      logic ci;
      a = W'($urandom); b = W'($urandom); ci = 1'($urandom);
      drive(a, b, 4'd6, 4'd1, 4'd6, 2'd0, ci);
      check("R6 add", {cout, result}, {1'b0, a} + {1'b0, b});
      drive(a, b, 4'd6, 4'd1, 4'd6, 2'd2, ci);
      check("R6 adc", {cout, result}, {1'b0, a} + {1'b0, b} + (W+1)'(ci));
    end
    drive(8'hFF, 8'h00, 4'd6, 4'd1, 4'd6, 2'd2, 1'b1);
    check("R6 ripple", {cout, result}, 9'h100);
  endtask

  task automatic t_increment;
    drive(8'hFF, 8'h00, 4'd12, 4'd3, 4'd6, 2'd1, 1'b0);
    check("R7 wrap", {cout, result}, 9'h100);
    drive(8'h7F, 8'hFF, 4'd12, 4'd3, 4'd6, 2'd1, 1'b0);
    check("R7", {cout, result}, 9'h080);
    for (int n = 0; n < 10; n++) begin
      logic [W-1:0] a;
      a = W'($urandom);
      drive(a, W'($urandom), 4'd12, 4'd3, 4'd6, 2'd1, 1'b0);
      check("R7", {cout, result}, {1'b0, a} + 9'd1);
    end
  endtask

  task automatic t_subtract;
    drive(8'h10, 8'h20, 4'd9, 4'd4, 4'd9, 2'd0, 1'b0);
    check("R8 borrow", {cout, result}, {1'b1, 8'hF0});
    drive(8'h20, 8'h20, 4'd9, 4'd4, 4'd9, 2'd2, 1'b1);
    check("R8 bin", {cout, result}, {1'b1, 8'hFF});
    drive(8'h20, 8'h20, 4'd9, 4'd4, 4'd9, 2'd0, 1'b0);
    check("R8 equal", {cout, result}, 9'h000);
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] a, b;
      logic bi;
      a = W'($urandom); b = W'($urandom); bi = 1'($urandom);
      drive(a, b, 4'd9, 4'd4, 4'd9, 2'd2, bi);
      check("R8", {cout, result}, {1'b0, a} - {1'b0, b} - (W+1)'(bi));
    end
  endtask

  task automatic t_rsubtract;
    drive(8'h20, 8'h10, 4'd9, 4'd2, 4'd9, 2'd0, 1'b0);
    check("R9 borrow", {cout, result}, {1'b1, 8'hF0});
    for (int n = 0; n < 15; n++) begin
      logic [W-1:0] a, b;
      logic bi;
      a = W'($urandom); b = W'($urandom); bi = 1'($urandom);
      drive(a, b, 4'd9, 4'd2, 4'd9, 2'd2, bi);
      check("R9", {cout, result}, {1'b0, b} - {1'b0, a} - (W+1)'(bi));
    end
  endtask

  task automatic t_free_codes;
    for (int n = 0; n < 60; n++) begin
      logic [W-1:0] a, b;
      logic [3:0] p, k, r;
      logic [1:0] s;
      logic ci;
      a = W'($urandom); b = W'($urandom);
      p = 4'($urandom); k = 4'($urandom); r = 4'($urandom);
      s = 2'($urandom); ci = 1'($urandom);
      drive(a, b, p, k, r, s, ci);
      check("R4 R5", {cout, result}, slice_ref(a, b, p, k, r, s, ci));
    end
  endtask

  initial begin
    t_idle_state();
    t_logic_codes();
    t_carry_ignored();
    t_cin_select();
    t_add();
    t_increment();
    t_subtract();
    t_rsubtract();
    t_free_codes();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule